// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

The block sits between a clocked user port and an external asynchronous static RAM of 256K words by 16 bits with two byte lanes. A user raises a request with an 18-bit word address, a 16-bit write word, a 2-bit lane mask and a read/write flag, and holds these until the controller answers with a one-cycle acknowledge. The controller then runs a single access on the RAM pins. It drives the address, the active-low chip, output, write and per-lane enables, and a tri-state data bus.

All RAM timing minima are given as nanosecond parameters together with the clock period. The controller rounds each one up to whole clock cycles and uses one counter to pace every phase. The write-enable low window is stretched when the bus turnaround plus the data setup time is longer than the pulse minimum. A read holds chip and output enable low for the longest of the cycle, address and output-enable access times, and captures the bus on the last cycle of that window.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, with no request, the chip, output, write and both lane enables are high and acknowledge is low.
- R2: A write holds write enable low for WE_LOW = max(ceil(40/T), ceil(25/T)+ceil(25/T)) cycles, where T is the clock period in ns. It then keeps chip enable low with write enable high for max(1, ceil(55/T)-WE_LOW) recovery cycles. Acknowledge rises on the clock edge that ends recovery, and write enable is never low while chip enable is high.
- R3: The data drivers turn on only after write enable has been low for ceil(25/T) cycles. They carry the write word until recovery ends, and they are never on while output enable is low.
- R4: Mask bit 0 selects the lower lane (bits 7:0, enable ram_lo_n low) and mask bit 1 the upper lane (bits 15:8, ram_hi_n low). A lane whose mask bit is 0 keeps its enable high, so its RAM contents are unchanged by a write; mask 00 writes nothing.
- R5: A read holds chip and output enable low with write enable high for max(ceil(55/T), ceil(55/T), ceil(30/T)) cycles. It samples the bus on the last of those cycles and raises acknowledge on the next edge, with the word on ack_rdata.
- R6: In ack_rdata, a lane whose mask bit is 0 reads as zero.
- R7: While chip enable is low, the RAM address and both lane enables stay constant and equal the accepted request's address and mask.
- R8: Chip enable is high during the acknowledge cycle, so each pair of transactions is separated by at least one idle cycle. A request is accepted only when the controller is idle and acknowledge is low.
- R9: A write following a read is not accepted until ceil(20/T) cycles after the read's acknowledge edge, and the data drivers are off on the cycle after output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held until acknowledge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 16 | Read word, valid with acknowledge |
| ram_addr | output | 18 | RAM word address |
| ram_cs_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_lo_n | output | 1 | Lower lane enable, active low |
| ram_hi_n | output | 1 | Upper lane enable, active low |
| ram_dq | inout | 16 | RAM data bus |

## Verification
The bench builds the controller with its default values: a 10 ns clock, which gives a 6-cycle write-enable window, a 6-cycle read window and a 2-cycle read-to-write turnaround. With these values the turnaround-plus-setup term outgrows the 4-cycle pulse minimum. This makes the stretched write window and the one-cycle recovery floor visible at the pins. The 2-cycle turnaround lets a write directly after a read show a longer wait than any other back-to-back pair.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W = 18,
  parameter int LANE_W = 8,
  parameter int CLK_NS = 10,
  parameter int WC_NS  = 55,
  parameter int WP_NS  = 40,
  parameter int DW_NS  = 25,
  parameter int WHZ_NS = 25,
  parameter int RC_NS  = 55,
  parameter int AA_NS  = 55,
  parameter int OE_NS  = 30,
  parameter int OHZ_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_wr,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_mask,
  output logic                ack,
  output logic [2*LANE_W-1:0] ack_rdata,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_cs_n,
  output logic                ram_oe_n,
  output logic                ram_we_n,
  output logic                ram_lo_n,
  output logic                ram_hi_n,
  inout  wire  [2*LANE_W-1:0] ram_dq
);
  localparam int DATA_W  = 2 * LANE_W;
  localparam int C_WC    = (WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WP    = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DW    = (DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WHZ   = (WHZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_RC    = (RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_AA    = (AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OE    = (OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OHZ   = (OHZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int WE_LOW  = (C_WP > C_WHZ + C_DW) ? C_WP : C_WHZ + C_DW;
  localparam int REC_LEN = (C_WC - WE_LOW > 1) ? C_WC - WE_LOW : 1;
  localparam int RD_A    = (C_RC > C_AA) ? C_RC : C_AA;
  localparam int RD_LEN  = (RD_A > C_OE) ? RD_A : C_OE;
  localparam int MAX_A   = (WE_LOW > RD_LEN) ? WE_LOW : RD_LEN;
  localparam int MAX_B   = (REC_LEN > C_OHZ) ? REC_LEN : C_OHZ;
  localparam int MAXLEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_REC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, turn;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [1:0]        mask_q;
  logic              start, last, drive;

  assign start = (st == S_IDLE) && req && !ack && (!req_wr || turn == '0);
  assign last  = (st == S_RD  && cnt == CNT_W'(RD_LEN - 1)) ||
                 (st == S_WR  && cnt == CNT_W'(WE_LOW - 1)) ||
                 (st == S_REC && cnt == CNT_W'(REC_LEN - 1));
  assign drive = (st == S_WR && cnt >= CNT_W'(C_WHZ)) || (st == S_REC);

  assign ram_addr = addr_q;
  assign ram_cs_n = (st == S_IDLE);
  assign ram_oe_n = (st != S_RD);
  assign ram_we_n = (st != S_WR);
  assign ram_lo_n = (st == S_IDLE) || !mask_q[0];
  assign ram_hi_n = (st == S_IDLE) || !mask_q[1];
  assign ram_dq   = drive ? wdat_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      turn      <= '0;
      ack       <= 1'b0;
      addr_q    <= '0;
      wdat_q    <= '0;
      mask_q    <= '0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (turn != '0) turn <= turn - 1'b1;
      if (st == S_IDLE) begin
        if (start) begin
          addr_q <= req_addr;
          wdat_q <= req_wdata;
          mask_q <= req_mask;
          cnt    <= '0;
          st     <= req_wr ? S_WR : S_RD;
        end
      end else if (last) begin
        cnt <= '0;
        if (st == S_WR) begin
          st <= S_REC;
        end else begin
          st  <= S_IDLE;
          ack <= 1'b1;
        end
        if (st == S_RD) begin
          ack_rdata <= {mask_q[1] ? ram_dq[DATA_W-1:LANE_W] : {LANE_W{1'b0}},
                        mask_q[0] ? ram_dq[LANE_W-1:0]      : {LANE_W{1'b0}}};
          turn      <= CNT_W'(C_OHZ);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_cs_n);
  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> ram_oe_n);
  a_r3_drive_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> (!ram_we_n && $past(!ram_we_n)));
  a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> ram_we_n);
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |->
      ($stable(ram_addr) && $stable(ram_lo_n) && $stable(ram_hi_n)));
  a_r8_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ram_cs_n);
  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |=> !drive);
endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int CLK_NS  = 10;
  localparam int C_WHZ   = (25 + CLK_NS - 1) / CLK_NS;
  localparam int C_DW    = (25 + CLK_NS - 1) / CLK_NS;
  localparam int C_WP    = (40 + CLK_NS - 1) / CLK_NS;
  localparam int C_WC    = (55 + CLK_NS - 1) / CLK_NS;
  localparam int C_RD    = (55 + CLK_NS - 1) / CLK_NS;
  localparam int C_OHZ   = (20 + CLK_NS - 1) / CLK_NS;
  localparam int E_WLOW  = (C_WP > C_WHZ + C_DW) ? C_WP : C_WHZ + C_DW;
  localparam int E_REC   = (C_WC - E_WLOW > 1) ? C_WC - E_WLOW : 1;
  localparam int E_TURN  = (C_OHZ > 1) ? C_OHZ : 1;
  localparam int NV      = 13;

  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b1, 18'h00011, 16'hA5C3, 2'b11},
    {1'b0, 1'b0, 18'h00011, 16'h0000, 2'b11},
    {1'b0, 1'b1, 18'h3FF22, 16'h1234, 2'b01},
    {1'b0, 1'b0, 18'h3FF22, 16'h0000, 2'b11},
    {1'b0, 1'b1, 18'h3FF22, 16'hBE00, 2'b10},
    {1'b1, 1'b0, 18'h3FF22, 16'h0000, 2'b11},
    {1'b0, 1'b0, 18'h3FF22, 16'h0000, 2'b10},
    {1'b0, 1'b1, 18'h2AA33, 16'hFFFF, 2'b00},
    {1'b0, 1'b0, 18'h2AA33, 16'h0000, 2'b11},
    {1'b0, 1'b1, 18'h15544, 16'h0F0F, 2'b11},
    {1'b0, 1'b1, 18'h15555, 16'hF0F0, 2'b11},
    {1'b0, 1'b0, 18'h15544, 16'h0000, 2'b01},
    {1'b0, 1'b0, 18'h15555, 16'h0000, 2'b11}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, req_wr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic ack, ram_cs_n, ram_oe_n, ram_we_n, ram_lo_n, ram_hi_n;
  logic [15:0] ack_rdata;
  logic [17:0] ram_addr;
  wire  [15:0] ram_dq;
  logic [15:0] mem [256];
  logic [15:0] refm [256];
  int checks = 0, fails = 0;
  int lat, we_lo, drv, oe_lo, badpin;
  logic cs_at_ack;
  bit done = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .ack_rdata(ack_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_lo_n(ram_lo_n), .ram_hi_n(ram_hi_n), .ram_dq(ram_dq));

  assign ram_dq[7:0]  = (!ram_cs_n && !ram_oe_n && ram_we_n && !ram_lo_n) ?
                        mem[ram_addr[7:0]][7:0] : 8'hzz;
  assign ram_dq[15:8] = (!ram_cs_n && !ram_oe_n && ram_we_n && !ram_hi_n) ?
                        mem[ram_addr[7:0]][15:8] : 8'hzz;

  always @(posedge ram_we_n) begin
    if (!ram_cs_n) begin
      if (!ram_lo_n) mem[ram_addr[7:0]][7:0]  <= ram_dq[7:0];
      if (!ram_hi_n) mem[ram_addr[7:0]][15:8] <= ram_dq[15:8];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [17:0] a, input logic [15:0] d,
                     input logic [1:0] m);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
    lat = 0; we_lo = 0; drv = 0; oe_lo = 0; badpin = 0;
    do begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (!ram_we_n) we_lo++;
      if (!ram_oe_n) oe_lo++;
      if (wr && !ram_cs_n && ram_dq == d) drv++;
      if (!ram_cs_n && (ram_addr != a || ram_lo_n != !m[0] || ram_hi_n != !m[1]))
        badpin++;
    end while (!ack && lat < 60);
    cs_at_ack = ram_cs_n;
    req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 16'h0137) ^ 16'h5A00;
      refm[i] = 16'(i * 16'h0137) ^ 16'h5A00;
    end
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", int'(ram_cs_n), 1);
    chk("R1 strobes in reset", int'({ram_oe_n, ram_we_n, ram_lo_n, ram_hi_n}), 4'hF);
    chk("R1 ack in reset", int'(ack), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'({ram_cs_n, ram_oe_n, ram_we_n, ram_lo_n, ram_hi_n, ack}), 6'h3E);

    begin
      bit prev_rd = 0;
      for (int v = 0; v < NV; v++) begin
        bit gap, wr;
        logic [17:0] a;
        logic [15:0] d, exp_rd;
        logic [1:0] m;
        int exp_lat;
        {gap, wr, a, d, m} = VEC[v];
        if (gap) repeat (5) @(negedge clk);
        exp_lat = (wr ? E_WLOW + E_REC : C_RD) + 1 +
                  (gap ? 0 : ((wr && prev_rd) ? E_TURN : 1));
        exp_rd = {m[1] ? refm[a[7:0]][15:8] : 8'h00, m[0] ? refm[a[7:0]][7:0] : 8'h00};
        run(wr, a, d, m);
        if (wr) begin
          if (m[0]) refm[a[7:0]][7:0]  = d[7:0];
          if (m[1]) refm[a[7:0]][15:8] = d[15:8];
          chk(wr && !gap && prev_rd ? "R9 write after read latency" : "R2 write latency",
              lat, exp_lat);
          chk("R2 write enable low cycles", we_lo, E_WLOW);
          chk("R3 driven data cycles", drv, E_WLOW - C_WHZ + E_REC);
          chk("R3 no output enable in write", oe_lo, 0);
        end else begin
          chk("R5 read latency", lat, exp_lat);
          chk("R5 output enable low cycles", oe_lo, C_RD);
          chk("R5 no write enable in read", we_lo, 0);
          chk(m == 2'b11 ? "R5 read data" : "R6 masked read data", int'(ack_rdata), int'(exp_rd));
        end
        chk("R7 R4 address and lane enables", badpin, 0);
        chk("R8 chip enable high at ack", int'(cs_at_ack), 1);
        prev_rd = !wr;
      end
    end

    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 18'h00011; req_mask = 2'b11;
    @(negedge clk);
    chk("R8 accepted when idle", int'(ram_cs_n), 0);
    do @(negedge clk); while (!ack);
    chk("R8 ack cycle idle", int'(ram_cs_n), 1);
    @(negedge clk);
    chk("R8 no accept while ack high", int'(ram_cs_n), 1);
    req = 1'b0;
    @(negedge clk);
    chk("R4 mask 00 left word intact", int'(mem[8'h33]), int'(refm[8'h33]));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule